// File: doc/BRIEF.md
# Control-flow enforcement monitor

This block observes the stream of retired instructions and enforces two control-flow integrity rules in hardware. The first rule is branch-landing tracking. An indirect jump or indirect call arms a single expectation. The next instruction that retires must be the landing-marker instruction, and any other instruction raises a fault. Direct jumps and direct calls never arm this expectation.

The second rule is a protected return-address stack. Every call, direct or indirect, pushes the return address it supplies into private storage inside the block. Every return pops that storage and compares the popped value with the return address the program actually used. A call on a full stack, a return on an empty stack, and a return whose address disagrees with the stored copy each raise their own fault. The stored copies change only through calls and returns seen by the monitor.

Faults are sticky. After the first fault the block freezes its state and reports that fault's cause until reset. Each rule has its own enable. The decoder feeding the monitor asserts at most one class flag per retired instruction.

Top module: `cfe_monitor`

## Requirements
- R1: After reset, `fault_vld` is 0 and `fault_cause` is 0. The return stack is empty and no landing expectation is pending.
- R2: With `ibt_en` high, an indirect jump or indirect call arms the expectation. If the next retired instruction is not the landing marker, `fault_vld` goes to 1 with `fault_cause` = 1 on the clock edge that retires that instruction.
- R3: A landing marker retired right after a tracked branch consumes the expectation without a fault. Cycles with `retire_vld` low in between do not consume the expectation.
- R4: Direct jumps and direct calls arm no expectation. A landing marker with nothing pending behaves as a no-op.
- R5: With `ibt_en` low, indirect branches arm nothing and no landing fault is raised.
- R6: With `ss_en` high, calls push `ret_addr` and returns pop in LIFO order. A return whose `ret_addr` differs from the popped copy sets `fault_cause` = 2. A matching return raises nothing.
- R7: A call made while the stack already holds `DEPTH` (default 16) entries sets `fault_cause` = 3.
- R8: A return made while the stack is empty sets `fault_cause` = 4.
- R9: With `ss_en` low, calls and returns leave the stack untouched and raise no stack fault.
- R10: Once `fault_vld` is 1, it and `fault_cause` hold their values until reset, whatever instructions follow.
- R11: When one instruction both misses an armed landing and causes a stack fault, the reported cause is 1.
- R12: `ret_addr` presented with any instruction other than a call or a return does not change the stored return addresses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ibt_en | input | 1 | Enable for landing-marker tracking |
| ss_en | input | 1 | Enable for the return-address stack |
| retire_vld | input | 1 | An instruction retires this cycle |
| cls_jmp_dir | input | 1 | Retired instruction is a direct jump |
| cls_jmp_ind | input | 1 | Retired instruction is an indirect jump |
| cls_call_dir | input | 1 | Retired instruction is a direct call |
| cls_call_ind | input | 1 | Retired instruction is an indirect call |
| cls_ret | input | 1 | Retired instruction is a return |
| cls_land | input | 1 | Retired instruction is the landing marker |
| ret_addr | input | ADDR_W | Return address pushed by a call or used by a return |
| fault_vld | output | 1 | Sticky fault indication |
| fault_cause | output | 3 | 0 none, 1 landing missed, 2 return mismatch, 3 stack overflow, 4 stack underflow |

## Verification
A corrupted stack pointer or entry stays hidden until a return reaches it. It then shows up as a false mismatch or underflow, or as a missed mismatch, on the edge that retires that return, possibly many instructions after the corruption. A stuck or lost landing expectation shows up as a fault, or as a missing fault, on the very next retired instruction. The stimulus therefore mixes deep call nesting, returns that use the stored address, and tracked branches followed by both marker and non-marker instructions, with idle cycles between them. Because faults freeze the block, every random episode starts from reset.

// File: rtl/cfe_pkg.sv
package cfe_pkg;

   typedef enum logic [2:0] {
      CFE_OK           = 3'd0,
      CFE_LAND_MISS    = 3'd1,
      CFE_RET_MISMATCH = 3'd2,
      CFE_SS_OVERFLOW  = 3'd3,
      CFE_SS_UNDERFLOW = 3'd4
   } cfe_cause_e;

   localparam int CFE_CAUSE_W = 3;

endpackage

// File: rtl/cfe_land_track.sv
module cfe_land_track (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic halt,
   input  logic retire,
   input  logic tracked,
   input  logic is_land,
   output logic miss,
   output logic pending
);

   logic pending_q;
   logic step;

   assign step    = retire && !halt;
   assign miss    = step && pending_q && enable && !is_land;
   assign pending = pending_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pending_q <= 1'b0;
      end else if (step) begin
         pending_q <= enable && tracked;
      end
   end

   // R3
   land_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !(enable && tracked)) |=> !pending_q);

   // R10
   land_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halt |=> $stable(pending_q));

endmodule

// File: rtl/cfe_shadow_stack.sv
module cfe_shadow_stack #(
   parameter int DEPTH          = 16,
   parameter int ADDR_W         = 32,
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              halt,
   input  logic              retire,
   input  logic              push_req,
   input  logic              pop_req,
   input  logic [ADDR_W-1:0] addr,
   output logic              overflow,
   output logic              underflow,
   output logic              mismatch
);

   localparam int SP_W  = $clog2(DEPTH + 1);
   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   if (DEPTH < 2) begin : g_bad_depth
      $error("cfe_shadow_stack: DEPTH must be at least 2");
   end
   if (ADDR_W < 1) begin : g_bad_width
      $error("cfe_shadow_stack: ADDR_W must be positive");
   end

   logic [SP_W-1:0]   sp_q;
   logic              full, empty, active;
   logic              do_push, do_pop;
   logic [IDX_W-1:0]  top_idx;
   logic [IDX_W-1:0]  wr_idx;
   logic [ADDR_W-1:0] ent_v [DEPTH];
   logic [ADDR_W-1:0] top_val;

   assign full    = (sp_q == SP_W'(DEPTH));
   assign empty   = (sp_q == '0);
   assign active  = retire && !halt && enable;
   assign do_push = active && push_req && !full;
   assign do_pop  = active && pop_req && !empty;
   assign wr_idx  = IDX_W'(sp_q);
   assign top_idx = empty ? '0 : IDX_W'(sp_q - SP_W'(1));
   assign top_val = ent_v[top_idx];

   assign overflow  = active && push_req && full;
   assign underflow = active && pop_req && empty;
   assign mismatch  = do_pop && (top_val != addr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sp_q <= '0;
      end else if (do_push) begin
         sp_q <= sp_q + SP_W'(1);
      end else if (do_pop) begin
         sp_q <= sp_q - SP_W'(1);
      end
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      logic [ADDR_W-1:0] q;
      logic              we;
      assign we       = do_push && (wr_idx == IDX_W'(i));
      assign ent_v[i] = q;
      if (CLEAR_ON_RESET) begin : g_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q <= '0;
            end else if (we) begin
               q <= addr;
            end
         end
      end else begin : g_norst
         always_ff @(posedge clk) begin
            if (we) begin
               q <= addr;
            end
         end
      end
   end

   // R7
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sp_q <= SP_W'(DEPTH));

   // R6
   push_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
      do_push |=> (sp_q == $past(sp_q) + SP_W'(1)));

   // R6
   pop_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
      do_pop |=> (sp_q == $past(sp_q) - SP_W'(1)));

   // R9
   ss_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> $stable(sp_q));

   // R10
   ss_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halt |=> $stable(sp_q));

   // R8
   no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      underflow |-> !do_pop);

endmodule

// File: rtl/cfe_fault_reg.sv
module cfe_fault_reg
   import cfe_pkg::*;
(
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   land_miss,
   input  logic                   ret_mismatch,
   input  logic                   ss_overflow,
   input  logic                   ss_underflow,
   output logic                   fault,
   output logic [CFE_CAUSE_W-1:0] cause
);

   logic       fault_q;
   cfe_cause_e cause_q;
   cfe_cause_e cause_d;
   logic       any_d;

   always_comb begin
      cause_d = CFE_OK;
      if (land_miss) begin
         cause_d = CFE_LAND_MISS;
      end else if (ss_overflow) begin
         cause_d = CFE_SS_OVERFLOW;
      end else if (ss_underflow) begin
         cause_d = CFE_SS_UNDERFLOW;
      end else if (ret_mismatch) begin
         cause_d = CFE_RET_MISMATCH;
      end
   end

   assign any_d = land_miss || ret_mismatch || ss_overflow || ss_underflow;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fault_q <= 1'b0;
         cause_q <= CFE_OK;
      end else if (!fault_q && any_d) begin
         fault_q <= 1'b1;
         cause_q <= cause_d;
      end
   end

   assign fault = fault_q;
   assign cause = cause_q;

   // R10
   fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault_q |=> (fault_q && $stable(cause_q)));

   // R11
   land_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!fault_q && land_miss) |=> (cause_q == CFE_LAND_MISS));

   // R1
   cause_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault_q == (cause_q != CFE_OK));

endmodule

// File: rtl/cfe_monitor.sv
module cfe_monitor
   import cfe_pkg::*;
#(
   parameter int DEPTH          = 16,
   parameter int ADDR_W         = 32,
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ibt_en,
   input  logic              ss_en,
   input  logic              retire_vld,
   input  logic              cls_jmp_dir,
   input  logic              cls_jmp_ind,
   input  logic              cls_call_dir,
   input  logic              cls_call_ind,
   input  logic              cls_ret,
   input  logic              cls_land,
   input  logic [ADDR_W-1:0] ret_addr,
   output logic              fault_vld,
   output logic [2:0]        fault_cause
);

   logic halt;
   logic tracked, push_req;
   logic land_miss, land_pending;
   logic ss_ovf, ss_unf, ss_mism;

   assign tracked  = cls_jmp_ind || cls_call_ind;
   assign push_req = cls_call_dir || cls_call_ind;

   cfe_land_track u_land (
      .clk     (clk),
      .rst_n   (rst_n),
      .enable  (ibt_en),
      .halt    (halt),
      .retire  (retire_vld),
      .tracked (tracked),
      .is_land (cls_land),
      .miss    (land_miss),
      .pending (land_pending)
   );

   cfe_shadow_stack #(
      .DEPTH          (DEPTH),
      .ADDR_W         (ADDR_W),
      .CLEAR_ON_RESET (CLEAR_ON_RESET)
   ) u_stack (
      .clk       (clk),
      .rst_n     (rst_n),
      .enable    (ss_en),
      .halt      (halt),
      .retire    (retire_vld),
      .push_req  (push_req),
      .pop_req   (cls_ret),
      .addr      (ret_addr),
      .overflow  (ss_ovf),
      .underflow (ss_unf),
      .mismatch  (ss_mism)
   );

   cfe_fault_reg u_fault (
      .clk          (clk),
      .rst_n        (rst_n),
      .land_miss    (land_miss),
      .ret_mismatch (ss_mism),
      .ss_overflow  (ss_ovf),
      .ss_underflow (ss_unf),
      .fault        (fault_vld),
      .cause        (fault_cause)
   );

   assign halt = fault_vld;

   // decoder contract: one class per retired instruction
   class_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      retire_vld |-> $onehot0({cls_jmp_dir, cls_jmp_ind, cls_call_dir,
                               cls_call_ind, cls_ret, cls_land}));

   // R2
   land_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (land_pending && retire_vld && ibt_en && !cls_land && !fault_vld)
         |=> (fault_vld && fault_cause == 3'd1));

   // R4
   direct_no_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (retire_vld && !fault_vld && (cls_jmp_dir || cls_call_dir || cls_land))
         |=> !land_pending);

   // R5
   ibt_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ibt_en && retire_vld && !fault_vld) |=> !land_pending);

endmodule

// File: tb/sim_cfe_monitor.sv
`timescale 1ns/1ps
module sim_cfe_monitor;

   localparam int DEPTH = 16;
   localparam int AW    = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ibt_en = 1'b0, ss_en = 1'b0, retire_vld = 1'b0;
   logic          c_jd = 1'b0, c_ji = 1'b0, c_cd = 1'b0, c_ci = 1'b0;
   logic          c_rt = 1'b0, c_ld = 1'b0;
   logic [AW-1:0] ret_addr = '0;
   logic          fault_vld;
   logic [2:0]    fault_cause;

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;

   // model state
   logic [AW-1:0] m_stk [DEPTH];
   int            m_sp;
   bit            m_pend;
   bit            e_flt;
   logic [2:0]    e_cause;

   always #10 clk = ~clk;

   cfe_monitor #(.DEPTH(DEPTH), .ADDR_W(AW)) u0 (
      .clk(clk), .rst_n(rst_n), .ibt_en(ibt_en), .ss_en(ss_en),
      .retire_vld(retire_vld), .cls_jmp_dir(c_jd), .cls_jmp_ind(c_ji),
      .cls_call_dir(c_cd), .cls_call_ind(c_ci), .cls_ret(c_rt),
      .cls_land(c_ld), .ret_addr(ret_addr),
      .fault_vld(fault_vld), .fault_cause(fault_cause));

   // kinds: 0 idle, 1 jmp direct, 2 jmp indirect, 3 call direct,
   // 4 call indirect, 5 return, 6 landing marker, 7 plain instruction
   localparam int K_IDLE = 0, K_JD = 1, K_JI = 2, K_CD = 3, K_CI = 4,
                  K_RET = 5, K_LAND = 6, K_PLAIN = 7;

   function automatic logic [2:0] next_cause(int k, logic [AW-1:0] a);
      logic [2:0] c;
      c = 3'd0;
      if (ss_en && (k == K_CD || k == K_CI) && m_sp == DEPTH) c = 3'd3;
      if (ss_en && k == K_RET) begin
         if (m_sp == 0) c = 3'd4;
         else if (m_stk[m_sp-1] != a) c = 3'd2;
      end
      if (m_pend && ibt_en && k != K_LAND) c = 3'd1;
      return c;
   endfunction

   task automatic model_step(int k, logic [AW-1:0] a);
      logic [2:0] c;
      if (e_flt || k == K_IDLE) return;
      c = next_cause(k, a);
      if (ss_en && (k == K_CD || k == K_CI) && m_sp < DEPTH) begin
         m_stk[m_sp] = a;
         m_sp++;
      end else if (ss_en && k == K_RET && m_sp > 0) begin
         m_sp--;
      end
      m_pend = ibt_en && (k == K_JI || k == K_CI);
      if (c != 3'd0) begin
         e_flt   = 1'b1;
         e_cause = c;
      end
   endtask

   task automatic check(string tag);
      tests++;
      if (fault_vld !== e_flt || fault_cause !== e_cause) begin
         fails++;
         $display("FAIL %s: fault_vld=%0b cause=%0d expected fault_vld=%0b cause=%0d",
                  tag, fault_vld, fault_cause, e_flt, e_cause);
      end
   endtask

   // called at a falling edge; returns at the next falling edge after checking
   task automatic issue(int k, logic [AW-1:0] a, string tag);
      retire_vld = (k != K_IDLE);
      c_jd = (k == K_JD);  c_ji = (k == K_JI);
      c_cd = (k == K_CD);  c_ci = (k == K_CI);
      c_rt = (k == K_RET); c_ld = (k == K_LAND);
      ret_addr = a;
      model_step(k, a);
      @(negedge clk);
      check(tag);
   endtask

   task automatic do_reset(bit ibt, bit ss);
      @(negedge clk);
      rst_n = 1'b0;
      retire_vld = 1'b0;
      {c_jd, c_ji, c_cd, c_ci, c_rt, c_ld} = '0;
      ibt_en = ibt;
      ss_en  = ss;
      m_sp = 0; m_pend = 1'b0; e_flt = 1'b0; e_cause = 3'd0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 reset state");
   endtask

   initial begin
      int cyc;
      cyc = 0;
      while (!done) begin
         @(posedge clk);
         cyc++;
         if (cyc > 150000) begin
            fails++;
            tests++;
            $display("FAIL watchdog: run hung, actual=%0d cycles expected<150000", cyc);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
         end
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i < DEPTH; i++) m_stk[i] = '0;

      // R1
      do_reset(1'b1, 1'b1);

      // R2: indirect jump then a plain instruction
      issue(K_JI, 32'h0, "R2 arm");
      issue(K_PLAIN, 32'h0, "R2 miss");

      // R2: indirect call then a direct jump
      do_reset(1'b1, 1'b1);
      issue(K_CI, 32'h100, "R2 arm call");
      issue(K_JD, 32'h0, "R2 miss after call");

      // R3: idle gap keeps the expectation, marker consumes it
      do_reset(1'b1, 1'b1);
      issue(K_CI, 32'h2000, "R3 arm");
      issue(K_IDLE, 32'h0, "R3 idle");
      issue(K_IDLE, 32'h0, "R3 idle");
      issue(K_LAND, 32'h0, "R3 land");
      issue(K_PLAIN, 32'h0, "R3 after land");
      issue(K_RET, 32'h2000, "R3 ret");

      // R4: direct branches arm nothing, lone marker is a no-op
      do_reset(1'b1, 1'b1);
      issue(K_JD, 32'h0, "R4 jd");
      issue(K_PLAIN, 32'h0, "R4 after jd");
      issue(K_CD, 32'h44, "R4 cd");
      issue(K_PLAIN, 32'h0, "R4 after cd");
      issue(K_LAND, 32'h0, "R4 lone land");
      issue(K_LAND, 32'h0, "R4 lone land");
      issue(K_RET, 32'h44, "R4 ret");

      // R5: tracking disabled
      do_reset(1'b0, 1'b1);
      issue(K_JI, 32'h0, "R5 ji off");
      issue(K_PLAIN, 32'h0, "R5 no miss");
      issue(K_CI, 32'h8, "R5 ci off");
      issue(K_RET, 32'h8, "R5 no miss ret");

      // R6: nested LIFO, then mismatch
      do_reset(1'b1, 1'b1);
      issue(K_CD, 32'hA, "R6 push");
      issue(K_CD, 32'hB, "R6 push");
      issue(K_CD, 32'hC, "R6 push");
      issue(K_RET, 32'hC, "R6 pop");
      issue(K_RET, 32'hB, "R6 pop");
      issue(K_RET, 32'hA, "R6 pop");
      issue(K_CD, 32'h1234, "R6 push");
      issue(K_RET, 32'h1235, "R6 mismatch");

      // R7: fill to DEPTH, one more call overflows
      do_reset(1'b1, 1'b1);
      for (int i = 0; i < DEPTH; i++) issue(K_CD, 32'h1000 + i, "R7 fill");
      issue(K_CD, 32'hFFFF, "R7 overflow");

      // R8: return on empty
      do_reset(1'b1, 1'b1);
      issue(K_RET, 32'h5, "R8 underflow");

      // R9: stack disabled
      do_reset(1'b1, 1'b0);
      issue(K_RET, 32'h5, "R9 ret off");
      issue(K_CD, 32'h6, "R9 call off");
      issue(K_RET, 32'h7, "R9 ret off");
      ss_en = 1'b1;
      issue(K_RET, 32'h7, "R9 stack still empty");

      // R10: fault holds through further faults of other kinds
      do_reset(1'b1, 1'b1);
      issue(K_RET, 32'h1, "R10 first fault");
      issue(K_JI, 32'h0, "R10 hold");
      issue(K_PLAIN, 32'h0, "R10 hold");
      issue(K_CD, 32'h3, "R10 hold");
      issue(K_RET, 32'h9, "R10 hold");
      issue(K_IDLE, 32'h0, "R10 hold");

      // R11: landing miss and underflow on one instruction
      do_reset(1'b1, 1'b1);
      issue(K_JI, 32'h0, "R11 arm");
      issue(K_RET, 32'h77, "R11 priority");

      // R12: addresses on other instructions leave the stack alone
      do_reset(1'b1, 1'b1);
      issue(K_CD, 32'hCAFE, "R12 push");
      issue(K_JD, 32'hDEAD, "R12 jd addr");
      issue(K_PLAIN, 32'hBEEF, "R12 plain addr");
      issue(K_LAND, 32'h1111, "R12 land addr");
      issue(K_IDLE, 32'h2222, "R12 idle addr");
      issue(K_RET, 32'hCAFE, "R12 ret matches");

      // random episodes
      for (int ep = 0; ep < 40; ep++) begin
         do_reset(($urandom % 8) != 0, ($urandom % 8) != 0);
         for (int s = 0; s < 150; s++) begin
            int k;
            logic [AW-1:0] a;
            if (m_pend && ($urandom % 100) < 85) k = K_LAND;
            else k = int'($urandom % 8);
            a = $urandom;
            if (k == K_RET && m_sp > 0 && ($urandom % 10) != 0) a = m_stk[m_sp-1];
            issue(k, a, "R6/R2/R10 random");
         end
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule